// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Serial Bus

This block is a target on an SMBus-style two-wire bus that holds a small bank of 8-bit configuration registers and exposes all of them in parallel to the surrounding logic. It watches SCL and SDA, which must already be synchronized to the system clock. It pulls SDA low through an output-enable, so the pad outside forms the open-drain connection.

A host writes by sending the device address with the write direction, then a starting register index, then a byte count N, then N data bytes. To read, the host sends the address and index, issues a repeated Start and the address with the read direction, and then clocks in a byte count followed by register data. The index advances by one after every data byte.

Three strap inputs supply the low bits of the device address. The top strap also selects an alternate operating mode for the rest of the chip, so every address that needs that strap low also forces the alternate mode.

Top module: `smb_idx_slave`

## Requirements
- R1: The device address is `{ADDR_HI, strap_i}`, where ADDR_HI is a 4-bit parameter defaulting to 4'b1101 and strap_i[2] is bit 2 of the address. An address byte whose upper seven bits match is ACKed. On a mismatch the block never pulls SDA, ACKs nothing up to the next Start, and changes no register.
- R2: A write (address byte bit 0 = 0) ACKs the index byte, a nonzero count byte and each of the N data bytes. Data byte i is stored in register index+i.
- R3: A count byte of 00h is not ACKed, and no register changes in that transaction, including for data bytes sent after it.
- R4: Data bytes sent after the N counted bytes are not ACKed and are not stored.
- R5: A write to an index at or beyond NUM_REGS stores nothing but is still ACKed. A read at such an index returns 00h.
- R6: After a repeated Start and an address byte with bit 0 = 1, the block first sends a count equal to NUM_REGS minus the current index (00h if the index is at or beyond NUM_REGS). It then sends register data starting at that index, sending each byte MSB first.
- R7: While sending, a host ACK makes the block send the next byte. A host NACK makes it release SDA and wait for the next Start or Stop. A following transaction works normally.
- R8: A Stop at any point ends the transaction and releases SDA. Bytes already ACKed stay stored. A repeated Start keeps the current register index.
- R9: The block begins pulling SDA low only after a falling edge of SCL, never while SCL is high.
- R10: alt_mode_o is 1 exactly when strap_i[2] is 0 (when ALT_MODE_EN is 1).
- R11: After reset every register reads 00h and SDA is released.
- R12: regs_o carries register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| strap_i | input | 3 | Address strap pins; bit 2 also selects the alternate mode |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| alt_mode_o | output | 1 | Alternate mode request from the top strap |
| regs_o | output | NUM_REGS*8 | Parallel view of all registers |

## Verification
The bench sends multi-byte writes, single-byte writes, and block reads that the host ends early with a NACK. Together these separate correct index auto-increment from correct count handling. A zero count, a wrong address and surplus data bytes each show whether the block ignores what it must while still ACKing the right bytes. Writes and reads that run past the end of the bank show whether out-of-range accesses are dropped and return zero. A mid-byte Stop shows that bytes already ACKed are kept. A change of straps shows that address matching and the mode output follow the pins.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_TX, PH_IGN} phase_e;
   typedef enum logic [1:0] {FLD_ADDR, FLD_OFF, FLD_CNT, FLD_DATA} field_e;
endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      start_o = scl_i & scl_q & sda_q & ~sda_i;
      stop_o  = scl_i & scl_q & ~sda_q & sda_i;
      rise_o  = scl_i & ~scl_q;
      fall_o  = ~scl_i & scl_q;
   end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
   parameter int NUM_REGS = 8,
   parameter logic [7:0] INIT_VAL = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [7:0]            waddr_i,
   input  logic [7:0]            wdata_i,
   input  logic [7:0]            raddr_i,
   output logic [7:0]            rdata_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int LIDX = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam logic [7:0] NUM_B = 8'(NUM_REGS);

   logic [7:0] bank [NUM_REGS];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bank[k] <= INIT_VAL;
         else if (we_i && waddr_i == 8'(k))   bank[k] <= wdata_i;
      end
      assign regs_o[8*k +: 8] = bank[k];
   end

   always_comb begin
      if (raddr_i < NUM_B) rdata_o = bank[raddr_i[LIDX-1:0]];
      else                 rdata_o = 8'h00;
   end

   AST_WR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> (waddr_i < NUM_B)); // R5
endmodule

// File: rtl/smb_idx_ctrl.sv
module smb_idx_ctrl
   import smb_idx_pkg::*;
#(
   parameter int NUM_REGS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       rise_i,
   input  logic       fall_i,
   input  logic       sda_i,
   input  logic [6:0] dev_addr_i,
   input  logic [7:0] rdata_i,
   output logic [7:0] idx_o,
   output logic       we_o,
   output logic [7:0] waddr_o,
   output logic [7:0] wdata_o,
   output logic       sda_oe_o
);
   localparam logic [7:0] NUM_B = 8'(NUM_REGS);

   phase_e     ph;
   field_e     fld;
   logic [3:0] cnt;
   logic [7:0] sh, idx, left;
   logic       rd_q, mack;
   logic [7:0] avail, idx_nx;

   always_comb begin
      avail  = (idx < NUM_B) ? (NUM_B - idx) : 8'h00;
      idx_nx = (idx == 8'hFF) ? idx : idx + 8'h01;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE;  fld <= FLD_ADDR;  cnt <= '0;  sh <= '0;
         idx <= '0;  left <= '0;  rd_q <= 1'b0;  mack <= 1'b0;
         sda_oe_o <= 1'b0;  we_o <= 1'b0;  waddr_o <= '0;  wdata_o <= '0;
      end else begin
         we_o <= 1'b0;
         if (stop_i) begin
            ph <= PH_IDLE;  sda_oe_o <= 1'b0;  cnt <= '0;
         end else if (start_i) begin
            ph <= PH_RX;  fld <= FLD_ADDR;  cnt <= '0;  sda_oe_o <= 1'b0;
         end else begin
            case (ph)
               PH_RX: begin
                  if (rise_i) begin
                     if (cnt < 4'd8) sh <= {sh[6:0], sda_i};
                     if (cnt < 4'd9) cnt <= cnt + 4'd1;
                  end else if (fall_i && cnt == 4'd8) begin
                     case (fld)
                        FLD_ADDR: begin
                           if (sh[7:1] != dev_addr_i) ph <= PH_IGN;
                           else begin
                              sda_oe_o <= 1'b1;
                              rd_q     <= sh[0];
                              if (!sh[0]) fld <= FLD_OFF;
                           end
                        end
                        FLD_OFF: begin
                           idx <= sh;  sda_oe_o <= 1'b1;  fld <= FLD_CNT;
                        end
                        FLD_CNT: begin
                           if (sh == 8'h00) ph <= PH_IGN;
                           else begin
                              left <= sh;  sda_oe_o <= 1'b1;  fld <= FLD_DATA;
                           end
                        end
                        default: begin
                           if (left == 8'h00) ph <= PH_IGN;
                           else begin
                              left     <= left - 8'h01;
                              sda_oe_o <= 1'b1;
                              idx      <= idx_nx;
                              if (idx < NUM_B) begin
                                 we_o    <= 1'b1;
                                 waddr_o <= idx;
                                 wdata_o <= sh;
                              end
                           end
                        end
                     endcase
                  end else if (fall_i && cnt == 4'd9) begin
                     cnt <= '0;
                     if (rd_q && fld == FLD_ADDR) begin
                        ph       <= PH_TX;
                        sh       <= avail;
                        sda_oe_o <= ~avail[7];
                     end else begin
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               PH_TX: begin
                  if (rise_i) begin
                     if (cnt == 4'd8) mack <= ~sda_i;
                     if (cnt < 4'd9)  cnt  <= cnt + 4'd1;
                  end else if (fall_i) begin
                     if (cnt >= 4'd1 && cnt <= 4'd7) begin
                        sh       <= {sh[6:0], 1'b0};
                        sda_oe_o <= ~sh[6];
                     end else if (cnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                     end else if (cnt == 4'd9) begin
                        cnt <= '0;
                        if (mack) begin
                           sh       <= rdata_i;
                           sda_oe_o <= ~rdata_i[7];
                           idx      <= idx_nx;
                        end else begin
                           ph       <= PH_IGN;
                           sda_oe_o <= 1'b0;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign idx_o = idx;

   AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(fall_i)); // R9
   AST_ZERO_CNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fall_i && !start_i && !stop_i && ph == PH_RX && fld == FLD_CNT
            && cnt == 4'd8 && sh == 8'h00) |-> !sda_oe_o); // R3
   AST_IGN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IGN) |-> !sda_oe_o); // R1
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_i) |-> (ph == PH_IDLE && !sda_oe_o)); // R8
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave #(
   parameter int         NUM_REGS    = 8,
   parameter logic [3:0] ADDR_HI     = 4'b1101,
   parameter logic [7:0] INIT_VAL    = 8'h00,
   parameter bit         ALT_MODE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [2:0]            strap_i,
   output logic                  sda_oe_o,
   output logic                  alt_mode_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   if (NUM_REGS < 1 || NUM_REGS > 255) begin : g_bad_depth
      $error("smb_idx_slave: NUM_REGS must lie in 1..255");
   end

   logic       ev_start, ev_stop, ev_rise, ev_fall;
   logic       we;
   logic [7:0] waddr, wdata, idx, rdata;
   logic [6:0] dev_addr;

   assign dev_addr = {ADDR_HI, strap_i};

   if (ALT_MODE_EN) begin : g_alt
      assign alt_mode_o = ~strap_i[2];
   end else begin : g_no_alt
      assign alt_mode_o = 1'b0;
   end

   smb_line_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall)
   );

   smb_idx_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_i(ev_start), .stop_i(ev_stop), .rise_i(ev_rise), .fall_i(ev_fall),
      .sda_i(sda_i), .dev_addr_i(dev_addr), .rdata_i(rdata),
      .idx_o(idx), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
      .sda_oe_o(sda_oe_o)
   );

   smb_regbank #(.NUM_REGS(NUM_REGS), .INIT_VAL(INIT_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_i(idx), .rdata_o(rdata), .regs_o(regs_o)
   );
endmodule

// File: tb/smb_idx_slave_bench.sv
module smb_idx_slave_bench;
   localparam int NR = 8;
   localparam int Q  = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic sda_oe, alt_mode, sda_bus;
   logic [NR*8-1:0] regs;

   int n_cmp = 0, n_bad = 0, n_r9 = 0;
   bit chk_en = 1'b0;
   logic [7:0] model [NR];
   logic scl_d = 1'b1;

   always #2.5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   smb_idx_slave u_smb_idx_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
      .sda_oe_o(sda_oe), .alt_mode_o(alt_mode), .regs_o(regs)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R12/R2: register view compared against the model on every idle clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_en) begin
            for (int k = 0; k < NR; k++) begin
               n_cmp++;
               if (regs[8*k +: 8] !== model[k]) begin
                  n_bad++;
                  if (n_bad < 20)
                     $display("FAIL R12 reg %0d: actual %0h expected %0h", k, regs[8*k +: 8], model[k]);
               end
            end
         end
         if (scl && scl_d && sda_oe && !$past(sda_oe)) n_r9++; // R9 monitor
         scl_d <= scl;
      end
   end

   task automatic wt(input int n); repeat (n) @(negedge clk); endtask
   task automatic bus_start(); sda_m = 1; wt(Q); scl = 1; wt(Q); sda_m = 0; wt(Q); scl = 0; wt(Q); endtask
   task automatic bus_stop(); sda_m = 0; wt(Q); scl = 1; wt(Q); sda_m = 1; wt(Q); endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(Q); scl = 1; wt(Q); scl = 0; wt(1);
      end
      sda_m = 1; wt(Q); scl = 1; wt(2); ack = !sda_bus; wt(2); scl = 0; wt(1);
   endtask

   task automatic get_byte(input logic ack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         wt(Q); scl = 1; wt(2); b[i] = sda_bus; wt(2); scl = 0;
      end
      wt(1); sda_m = ack ? 1'b0 : 1'b1; wt(Q); scl = 1; wt(Q); scl = 0; wt(1); sda_m = 1;
   endtask

   function automatic logic [6:0] my_addr();
      return {4'b1101, strap};
   endfunction

   // write: sends all bytes, expects ACKs from the requirements, updates model
   task automatic do_write(input logic [6:0] a, input logic [7:0] off, input logic [7:0] n,
                           input logic [7:0] d[$], input string req);
      logic ack; bit ok;
      chk_en = 0;
      ok = (a == my_addr());
      bus_start();
      put_byte({a, 1'b0}, ack); chk({req, " addr ack (R1)"}, ack, ok);
      put_byte(off, ack);       chk({req, " offset ack (R2)"}, ack, ok);
      put_byte(n, ack);         ok = ok && (n != 0); chk({req, " count ack (R3)"}, ack, ok);
      for (int i = 0; i < d.size(); i++) begin
         put_byte(d[i], ack);
         chk({req, " data ack (R4/R5)"}, ack, ok && (i < n));
         if (ok && i < n && (off + i) < NR) model[off + i] = d[i];
      end
      bus_stop(); wt(4);
      chk({req, " SDA released (R8)"}, sda_oe, 0);
      chk_en = 1;
   endtask

   task automatic do_read(input logic [7:0] off, input int nrd, input string req);
      logic ack; logic [7:0] b;
      chk_en = 0;
      bus_start();
      put_byte({my_addr(), 1'b0}, ack); chk({req, " addr ack (R1)"}, ack, 1);
      put_byte(off, ack);               chk({req, " offset ack (R2)"}, ack, 1);
      bus_start();
      put_byte({my_addr(), 1'b1}, ack); chk({req, " read addr ack (R1)"}, ack, 1);
      get_byte(1'b1, b);
      chk({req, " count (R6)"}, b, (off < NR) ? NR - off : 0);
      for (int i = 0; i < nrd; i++) begin
         get_byte(i != nrd - 1, b);
         chk({req, " data (R6/R5)"}, b, (off + i < NR) ? model[off + i] : 8'h00);
      end
      wt(2); chk({req, " released after NACK (R7)"}, sda_oe, 0);
      bus_stop(); wt(4);
      chk_en = 1;
   endtask

   initial begin
      logic ack;
      for (int k = 0; k < NR; k++) model[k] = 8'h00;
      wt(5); rst_n = 1; wt(3);
      chk("R11 SDA after reset", sda_oe, 0);
      chk("R11 regs after reset", (regs == '0), 1);
      chk("R10 alt mode strap2=1", alt_mode, 0);
      chk_en = 1;

      do_write(my_addr(), 8'd1, 8'd3, '{8'hA1, 8'hB2, 8'hC3}, "R2 block");
      do_write(my_addr(), 8'd7, 8'd1, '{8'h5A}, "R2 single");
      do_read(8'd0, 8, "R6 full");
      do_read(8'd2, 3, "R7 early NACK");
      do_read(8'd5, 1, "R6 single");
      do_write(my_addr(), 8'd0, 8'd0, '{8'hFF, 8'hEE}, "R3 zero count");
      do_write(7'h6C, 8'd0, 8'd2, '{8'h12, 8'h34}, "R1 wrong addr");
      do_write(my_addr(), 8'd4, 8'd2, '{8'h11, 8'h22, 8'h33}, "R4 extra");
      do_write(my_addr(), 8'd6, 8'd4, '{8'h44, 8'h55, 8'h66, 8'h77}, "R5 past end");
      do_read(8'd9, 1, "R5 read beyond");
      do_read(8'd6, 4, "R5 read across end");

      // R8: Stop in the middle of the second data byte
      chk_en = 0;
      bus_start();
      put_byte({my_addr(), 1'b0}, ack);
      put_byte(8'd2, ack);
      put_byte(8'd3, ack);
      put_byte(8'h9C, ack); chk("R8 first data ack", ack, 1);
      model[2] = 8'h9C;
      for (int i = 0; i < 3; i++) begin
         sda_m = 1'b1; wt(Q); scl = 1; wt(Q); scl = 0; wt(1);
      end
      bus_stop(); wt(4);
      chk("R8 released after mid-byte stop", sda_oe, 0);
      chk_en = 1;
      do_read(8'd2, 2, "R8 after abort");

      // R1/R10: new straps
      strap = 3'b011; wt(4);
      chk("R10 alt mode strap2=0", alt_mode, 1);
      do_write(7'h6D, 8'd0, 8'd1, '{8'hAB}, "R1 old addr");
      do_write(my_addr(), 8'd0, 8'd1, '{8'hCD}, "R1 new addr");
      do_read(8'd0, 2, "R1 new addr read");

      chk("R9 no SDA pull while SCL high", n_r9, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule